// File: doc/BRIEF.md
# DMA channel control and status register block

This block holds the software-visible registers of one DMA channel and turns writes to them into control signals for the attached peripheral. Four 32-bit words sit in a 16-byte window on a word-only bus. Word 0 is the control/status word. Word 1 is the transfer address. Words 2 and 3 are plain storage, and word 3 also feeds the high address bits of a companion data path.

The control/status word gates the peripheral's interrupt request onto the channel interrupt output. It also drives a level that enables DMA in the peripheral and a one-cycle reset pulse to the peripheral. Several bits are protected and keep their stored values on a write: the version field, the address-loaded flag and the low status bits. A write of all zeros is stored as a drain request.

Read data is registered and appears the cycle after the read. Every side effect of a write appears the cycle after the write.

Top module: `chan_ctl_regs`

## Requirements
- R1: After reset, word 0 reads 0xA0000000, words 1 to 3 read 0, and irq_o, prst_o and dma_en_o are 0.
- R2: The word index is addr_i[3:2], and addr_i[1:0] is ignored. After a read request, rdata_o holds the indexed word from the next cycle on.
- R3: Bits in mask 0xFE000007 of word 0 are not changed by a write to word 0, and bits 31:28 always read 0xA. All other bits take the written value, except as R8 states.
- R4: A write to word 1 stores the value, and sets bit 26 (loaded) of word 0 in the same edge.
- R5: Bit 0 of word 0 (pending) equals irq_req_i as sampled at the previous clock edge.
- R6: irq_o is 1 exactly when pending and bit 4 (interrupt enable) of word 0 are both 1. It follows the register state with no extra delay, so setting the enable while an interrupt is pending raises irq_o in the cycle after the write.
- R7: A write to word 0 with bit 7 set drives prst_o high for exactly the one cycle after the write. Bit 7 is stored as written.
- R8: Bit 6 (drain) handling when bit 7 is clear: a write with bit 6 set stores bit 6 as 0, and a write of 0x00000000 stores bit 6 as 1. When bit 7 is set, bit 6 is stored as written.
- R9: dma_en_o equals bit 9 of word 0 and changes in the cycle after the write that changes that bit.
- R10: Words 2 and 3 store any written value, and hi_addr_o presents word 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | ADDR_W | Byte address inside the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_req_i | input | 1 | Interrupt request level from the peripheral |
| irq_o | output | 1 | Channel interrupt |
| prst_o | output | 1 | One-cycle reset pulse to the peripheral |
| dma_en_o | output | 1 | DMA enable level to the peripheral |
| hi_addr_o | output | 32 | Word 3, the high address for the data path |

## Verification
A change on the peripheral's interrupt request and a write that flips the interrupt enable can land on the same edge. Both feed the next pending and enable state that drives irq_o. The bench raises irq_req_i in the same cycle as a write that sets the enable, and expects irq_o high and pending set one cycle later. It then drops the request in the same cycle as a write that clears the enable, and expects both low. The written bits are swept one at a time across the whole word, and each read-back is compared with a value the bench works out from the protection mask, the drain rules and the current request level.

// File: rtl/chan_ctl_pkg.sv
package chan_ctl_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned B_PEND   = 0;
  localparam int unsigned B_IEN    = 4;
  localparam int unsigned B_DRAIN  = 6;
  localparam int unsigned B_PRST   = 7;
  localparam int unsigned B_TOMEM  = 8;
  localparam int unsigned B_EN     = 9;
  localparam int unsigned B_LOADED = 26;
  localparam logic [DW-1:0] RO_MASK  = 32'hFE00_0007;
  localparam logic [DW-1:0] VER_BITS = 32'hA000_0000;
endpackage

// File: rtl/chan_ctl_wfilter.sv
// Turns a bus write into the next control word value.
module chan_ctl_wfilter
  import chan_ctl_pkg::*;
(
  input  logic [DW-1:0] cur_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] nxt_o,
  output logic          prst_req_o
);
  logic [DW-1:0] v;

  always_comb begin
    v = wdata_i;
    if (!wdata_i[B_PRST]) begin
      if (wdata_i[B_DRAIN])  v[B_DRAIN] = 1'b0;
      else if (wdata_i == '0) v[B_DRAIN] = 1'b1;
    end
    nxt_o      = (cur_i & RO_MASK) | (v & ~RO_MASK) | VER_BITS;
    prst_req_o = wdata_i[B_PRST];
  end
endmodule

// File: rtl/chan_ctl_side.sv
// Registered side-band outputs, taken from the next control state.
module chan_ctl_side (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_d_i,
  input  logic ien_d_i,
  input  logic en_d_i,
  input  logic prst_req_i,
  output logic irq_o,
  output logic prst_o,
  output logic dma_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o    <= 1'b0;
      prst_o   <= 1'b0;
      dma_en_o <= 1'b0;
    end else begin
      irq_o    <= pend_d_i & ien_d_i;
      prst_o   <= prst_req_i;
      dma_en_o <= en_d_i;
    end
  end

  // R7: a pulse only follows a requesting write
  a_r7_pulse_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prst_req_i |=> !prst_o);
endmodule

// File: rtl/chan_ctl_regs.sv
module chan_ctl_regs
  import chan_ctl_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              irq_req_i,
  output logic              irq_o,
  output logic              prst_o,
  output logic              dma_en_o,
  output logic [DW-1:0]     hi_addr_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);
  localparam logic [IDX_W-1:0] IDX_CTL  = '0;
  localparam logic [IDX_W-1:0] IDX_ADDR = IDX_W'(1);

  logic [IDX_W-1:0] idx;
  logic             wr, rd, wr_ctl, wr_addr, prst_req, unused_addr;
  logic [DW-1:0]    ctl_q, ctl_d, ctl_w;
  logic [DW-1:0]    word_q [NUM_REGS];

  assign idx         = addr_i[IDX_W+1:2];
  assign unused_addr = ^addr_i[1:0];
  assign wr          = req_i & we_i;
  assign rd          = req_i & ~we_i;
  assign wr_ctl      = wr && (idx == IDX_CTL);
  assign wr_addr     = wr && (idx == IDX_ADDR);

  chan_ctl_wfilter u_wf (
    .cur_i(ctl_q), .wdata_i(wdata_i), .nxt_o(ctl_w), .prst_req_o(prst_req)
  );

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl)  ctl_d = ctl_w;
    if (wr_addr) ctl_d[B_LOADED] = 1'b1;
    ctl_d[B_PEND] = irq_req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= VER_BITS;
    else         ctl_q <= ctl_d;
  end

  // data words; index 0 is never written and reads through ctl_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) word_q[i] <= '0;
    end else if (wr && idx != IDX_CTL) begin
      word_q[idx] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= (idx == IDX_CTL) ? ctl_q : word_q[idx];
  end

  assign hi_addr_o = word_q[NUM_REGS-1];

  chan_ctl_side u_side (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pend_d_i(ctl_d[B_PEND]), .ien_d_i(ctl_d[B_IEN]), .en_d_i(ctl_d[B_EN]),
    .prst_req_i(wr_ctl & prst_req),
    .irq_o(irq_o), .prst_o(prst_o), .dma_en_o(dma_en_o)
  );

  // R3
  a_r3_version: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q[31:28] == 4'hA);
  // R4
  a_r4_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_addr |=> ctl_q[B_LOADED]);
  // R5
  a_r5_pend_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_i |=> ctl_q[B_PEND]);
  a_r5_pend_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_req_i |=> !ctl_q[B_PEND]);
  // R6
  a_r6_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (ctl_q[B_PEND] & ctl_q[B_IEN]));
  // R7
  a_r7_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl && wdata_i[B_PRST]) |=> prst_o);
  // R9
  a_r9_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_en_o == ctl_q[B_EN]);
endmodule

// File: tb/sim_chan_ctl_regs.sv
`timescale 1ns/1ps
module sim_chan_ctl_regs;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, irq_req = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, hi_addr;
  logic        irq, prst, dma_en;
  int          checks = 0, errors = 0;
  logic [31:0] exp_ctl;
  logic [31:0] exp_w [4];

  always #2 clk = ~clk;

  chan_ctl_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_req_i(irq_req), .irq_o(irq),
    .prst_o(prst), .dma_en_o(dma_en), .hi_addr_o(hi_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected control word after a write, built from R3 and R8
  function automatic logic [31:0] ctl_after(input logic [31:0] old, input logic [31:0] v);
    logic [31:0] s = v;
    if (!v[7]) begin
      if (v[6]) s[6] = 1'b0;
      else if (v == 32'h0) s[6] = 1'b1;
    end
    return (old & 32'hFE00_0007) | (s & 32'h01FF_FFF8) | 32'hA000_0000;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic chk_side(input string tag);
    chk({tag, " R6 irq"}, {31'h0, irq}, {31'h0, exp_ctl[0] & exp_ctl[4]});
    chk({tag, " R9 en"},  {31'h0, dma_en}, {31'h0, exp_ctl[9]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    exp_ctl = 32'hA000_0000;
    for (int i = 0; i < 4; i++) exp_w[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 prst", {31'h0, prst}, 32'h0);
    chk("R1 en", {31'h0, dma_en}, 32'h0);
    rd(4'h0, "R1 ctl", 32'hA000_0000);
    for (int r = 1; r < 4; r++) rd(4'(r * 4), "R1 word", 32'h0);

    // R3 R7 R8 R9: walk a single set bit across the control word
    for (int b = 0; b < 32; b++) begin
      wr(4'h0, 32'h1 << b);
      exp_ctl = ctl_after(exp_ctl, 32'h1 << b);
      chk("R7 pulse", {31'h0, prst}, {31'h0, (b == 7)});
      chk_side("walk");
      rd(4'h0, "R3 walk", exp_ctl);
      chk("R7 pulse end", {31'h0, prst}, 32'h0);
    end

    // R8 drain corner cases
    wr(4'h0, 32'h0);         exp_ctl = ctl_after(exp_ctl, 32'h0);
    rd(4'h0, "R8 zero write", exp_ctl);
    chk("R8 zero sets drain", {31'h0, exp_ctl[6]}, 32'h1);
    wr(4'h0, 32'h0000_0040); exp_ctl = ctl_after(exp_ctl, 32'h40);
    rd(4'h0, "R8 drain clear", exp_ctl);
    wr(4'h0, 32'h0000_00C0); exp_ctl = ctl_after(exp_ctl, 32'hC0);
    chk("R7 with drain", {31'h0, prst}, 32'h1);
    rd(4'h0, "R8 drain kept with reset", exp_ctl);
    wr(4'h0, 32'hFFFF_FFFF); exp_ctl = ctl_after(exp_ctl, 32'hFFFF_FFFF);
    chk_side("ones");
    rd(4'h0, "R3 all ones", exp_ctl);

    // R4 R10 R2: data words, alias through low address bits
    for (int r = 1; r < 4; r++) begin
      wr(4'(r * 4), 32'h1234_5670 + 32'(r));
      exp_w[r] = 32'h1234_5670 + 32'(r);
      if (r == 1) exp_ctl[26] = 1'b1;
    end
    for (int r = 1; r < 4; r++) rd(4'(r * 4 + 3), "R2 R10 word", exp_w[r]);
    rd(4'h2, "R4 loaded", exp_ctl);
    chk("R10 hi_addr", hi_addr, exp_w[3]);
    wr(4'h0, 32'h0); exp_ctl = ctl_after(exp_ctl, 32'h0);
    rd(4'h0, "R4 loaded protected", exp_ctl);

    // R5 R6: request and enable, separately and together
    @(negedge clk); irq_req = 1'b1;
    @(negedge clk); exp_ctl[0] = 1'b1;
    chk_side("R5 pend no en");
    rd(4'h0, "R5 pend set", exp_ctl);
    wr(4'h0, 32'h10); exp_ctl = ctl_after(exp_ctl, 32'h10);
    chk_side("R6 enable while pending");
    @(negedge clk); irq_req = 1'b0;
    @(negedge clk); exp_ctl[0] = 1'b0;
    chk_side("R5 drop");
    rd(4'h0, "R5 pend clr", exp_ctl);
    wr(4'h0, 32'h0);  exp_ctl = ctl_after(exp_ctl, 32'h0);
    // same edge: request rises with the enable write
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 4'h0; wdata = 32'h210; irq_req = 1'b1;
    @(negedge clk); req = 1'b0; we = 1'b0;
    exp_ctl = ctl_after(exp_ctl, 32'h210); exp_ctl[0] = 1'b1;
    chk_side("R6 same edge rise");
    // same edge: request falls with the disabling write
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 4'h0; wdata = 32'h100; irq_req = 1'b0;
    @(negedge clk); req = 1'b0; we = 1'b0;
    exp_ctl = ctl_after(exp_ctl, 32'h100); exp_ctl[0] = 1'b0;
    chk_side("R6 same edge fall");
    rd(4'h0, "R5 R6 final ctl", exp_ctl);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule